// File: doc/BRIEF.md
# Palette DAC Access Sequencer

This block is the processor-facing side of a color lookup table. The table has 256 entries, and each entry holds three bytes. A simple byte-wide I/O bus reaches the table through four ports, selected by a 2-bit address:

- one port sets the index for reading,
- one port sets the index for writing,
- one port carries the color bytes,
- one port reports whether the last index loaded was a read or a write.

An entry is transferred as three back-to-back accesses on the data port. A single byte counter, shared by the read path and the write path, picks which byte of the entry comes next.

On the write side, the first two bytes are held in a staging cache. The third byte writes all three into the table together, so the table never holds a half-written entry. When an entry finishes, in either direction, the matching index advances by one and wraps from the last entry to the first.

Read data is registered. A read strobe sampled on a clock edge shows its byte on `rdata` after that same edge, and `rdata` holds that value until the next accepted read. The table itself is a register array inside the block. It is cleared by reset, together with both indices, the byte counter, the mode flag and `rdata`.

Top module: `palDacSequencer`

## Requirements
- R1: A write to port 0 (`addr`=0) loads the read index from `wdata` and clears the byte counter. It also sets the state value to 3.
- R2: A write to port 1 (`addr`=1) loads the write index from `wdata` and clears the byte counter. It also sets the state value to 0.
- R3: A write to port 2 (`addr`=2) stores `wdata` in staging slot [byte counter]. The counter then steps 0→1→2 and never reaches 3.
- R4: The write to port 2 that arrives at counter value 2 commits the three bytes to entry [write index] in arrival order. The counter returns to 0 and the write index increments.
- R5: After one or two data writes, the addressed entry still reads back its previous contents. Loading either index in between discards the partial entry.
- R6: A read of port 2 returns byte [byte counter] of entry [read index] and advances the counter. After the third byte, the counter returns to 0 and the read index increments.
- R7: Reads return on `rdata` one edge after the strobe. Port 3 returns the state value, port 1 returns the write index, and port 0 returns 0x00.
- R8: The read index and the write index each wrap from 255 to 0.
- R9: When `wrEn` and `rdEn` are high in the same cycle, only the write takes effect. `rdata` and the byte counter see no read.
- R10: Reset clears both indices, the byte counter, the state value, every table byte and `rdata`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe, one access per high cycle |
| rdEn | input | 1 | Read strobe, one access per high cycle |
| addr | input | 2 | Port select: 0 read index, 1 write index, 2 data, 3 state |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Registered read data byte |

## Verification
A data-port write and a data-port read both move the shared byte counter, and the bus allows both strobes in one cycle. The bench provokes this by raising `wrEn` and `rdEn` together on the data port, right after a port-1 read has left a known value on `rdata`. It then judges the outcome in three ways:

- `rdata` must still hold that earlier value.
- Two further data writes must be enough to complete the entry.
- Reading the entry back must show the colliding byte in slot 0, which proves the counter advanced only once.

// File: rtl/palDacPkg.sv
package palDacPkg;

  localparam int BYTES_PER_ENTRY = 3;
  localparam int SUB_W = $clog2(BYTES_PER_ENTRY);

  typedef enum logic [1:0] {
    PORT_RD_IDX = 2'd0,
    PORT_WR_IDX = 2'd1,
    PORT_DATA   = 2'd2,
    PORT_STATE  = 2'd3
  } palPort_e;

  // Strobes from control to datapath, one cycle each.
  typedef struct packed {
    logic     loadRdIdx;
    logic     loadWrIdx;
    logic     dataWr;
    logic     dataRd;
    logic     lastByte;
    logic     rdCapture;
    palPort_e rdSel;
  } palStrobe_t;

endpackage

// File: rtl/palDacCtrl.sv
module palDacCtrl
  import palDacPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [1:0]       addr,
  output palStrobe_t       strb,
  output logic [SUB_W-1:0] subIdx,
  output logic             readMode
);

  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(BYTES_PER_ENTRY - 1);

  palPort_e port;
  logic     rdFire;
  logic     dataStep;

  assign port = palPort_e'(addr);

  // Write wins a collision; the read is dropped entirely (R9).
  assign rdFire = rdEn && !wrEn;

  always_comb begin
    strb           = '0;
    strb.loadRdIdx = wrEn && (port == PORT_RD_IDX);
    strb.loadWrIdx = wrEn && (port == PORT_WR_IDX);
    strb.dataWr    = wrEn && (port == PORT_DATA);
    strb.dataRd    = rdFire && (port == PORT_DATA);
    strb.lastByte  = (subIdx == SUB_LAST);
    strb.rdCapture = rdFire;
    strb.rdSel     = port;
  end

  assign dataStep = strb.dataWr || strb.dataRd;

  // Shared byte counter for both directions.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      subIdx <= '0;
    end else if (strb.loadRdIdx || strb.loadWrIdx) begin
      subIdx <= '0;
    end else if (dataStep) begin
      subIdx <= strb.lastByte ? '0 : subIdx + SUB_W'(1);
    end
  end

  // Mode flag behind the state port: 1 after a read-index load.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      readMode <= 1'b0;
    end else if (strb.loadRdIdx) begin
      readMode <= 1'b1;
    end else if (strb.loadWrIdx) begin
      readMode <= 1'b0;
    end
  end

endmodule

// File: rtl/palDacPath.sv
module palDacPath
  import palDacPkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ENTRIES = 256,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  palStrobe_t        strb,
  input  logic [SUB_W-1:0]  subIdx,
  input  logic              readMode,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int ENTRY_W    = BYTES_PER_ENTRY * DATA_W;
  localparam int CACHE_SLOTS = BYTES_PER_ENTRY - 1;

  logic [IDX_W-1:0]   rdIdx;
  logic [IDX_W-1:0]   wrIdx;
  logic [DATA_W-1:0]  cacheByte [CACHE_SLOTS];
  logic [ENTRY_W-1:0] palMem    [ENTRIES];
  logic [ENTRY_W-1:0] commitWord;
  logic [ENTRY_W-1:0] rdEntry;
  logic [DATA_W-1:0]  rdByte;
  logic [DATA_W-1:0]  stateByte;
  logic               commit;

  // Staging slots; the final byte bypasses the cache.
  for (genvar g = 0; g < CACHE_SLOTS; g++) begin : g_cache
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cacheByte[g] <= '0;
      end else if (strb.dataWr && (subIdx == SUB_W'(g))) begin
        cacheByte[g] <= wdata;
      end
    end
  end

  always_comb begin
    commitWord = '0;
    for (int k = 0; k < CACHE_SLOTS; k++) begin
      commitWord[k*DATA_W +: DATA_W] = cacheByte[k];
    end
    commitWord[CACHE_SLOTS*DATA_W +: DATA_W] = wdata;
  end

  assign commit = strb.dataWr && strb.lastByte;

  // Indices wrap naturally at the power-of-two table size.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdIdx <= '0;
      wrIdx <= '0;
    end else begin
      if (strb.loadRdIdx) begin
        rdIdx <= wdata[IDX_W-1:0];
      end else if (strb.dataRd && strb.lastByte) begin
        rdIdx <= rdIdx + IDX_W'(1);
      end
      if (strb.loadWrIdx) begin
        wrIdx <= wdata[IDX_W-1:0];
      end else if (commit) begin
        wrIdx <= wrIdx + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int e = 0; e < ENTRIES; e++) begin
        palMem[e] <= '0;
      end
    end else if (commit) begin
      palMem[wrIdx] <= commitWord;
    end
  end

  assign rdEntry = palMem[rdIdx];

  always_comb begin
    rdByte = '0;
    for (int k = 0; k < BYTES_PER_ENTRY; k++) begin
      if (subIdx == SUB_W'(k)) begin
        rdByte = rdEntry[k*DATA_W +: DATA_W];
      end
    end
  end

  assign stateByte = readMode ? DATA_W'(3) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdata <= '0;
    end else if (strb.rdCapture) begin
      unique case (strb.rdSel)
        PORT_RD_IDX: rdata <= '0;
        PORT_WR_IDX: rdata <= DATA_W'(wrIdx);
        PORT_DATA:   rdata <= rdByte;
        PORT_STATE:  rdata <= stateByte;
        default:     rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/palDacSequencer.sv
module palDacSequencer
  import palDacPkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ENTRIES = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int IDX_W = $clog2(ENTRIES);

  palStrobe_t       strb;
  logic [SUB_W-1:0] subIdx;
  logic             readMode;

  palDacCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .addr     (addr),
    .strb     (strb),
    .subIdx   (subIdx),
    .readMode (readMode)
  );

  palDacPath #(
    .DATA_W  (DATA_W),
    .ENTRIES (ENTRIES),
    .IDX_W   (IDX_W)
  ) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .subIdx   (subIdx),
    .readMode (readMode),
    .wdata    (wdata),
    .rdata    (rdata)
  );

endmodule

// File: rtl/palDacSequencer_chk.sv
module palDacSequencer_chk
  import palDacPkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [1:0]        addr,
  input logic [DATA_W-1:0] rdata,
  input logic [SUB_W-1:0]  subIdx,
  input logic              readMode
);

  logic dataAcc;
  assign dataAcc = (addr == 2'd2) && (wrEn || rdEn);

  a_r1_load_read: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 2'd0) |=> (subIdx == '0 && readMode));

  a_r2_load_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 2'd1) |=> (subIdx == '0 && !readMode));

  a_r3_sub_step: assert property (@(posedge clk) disable iff (!rstN)
    (dataAcc && subIdx != SUB_W'(BYTES_PER_ENTRY - 1)) |=> (subIdx == $past(subIdx) + SUB_W'(1)));

  a_r3_sub_range: assert property (@(posedge clk) disable iff (!rstN)
    subIdx < SUB_W'(BYTES_PER_ENTRY));

  a_r4_sub_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (dataAcc && subIdx == SUB_W'(BYTES_PER_ENTRY - 1)) |=> (subIdx == '0));

  a_r9_collide_hold: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && rdEn) |=> $stable(rdata));

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !rdEn) |=> ($stable(rdata) && $stable(subIdx)));

endmodule

bind palDacSequencer palDacSequencer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .rdEn     (rdEn),
  .addr     (addr),
  .rdata    (rdata),
  .subIdx   (subIdx),
  .readMode (readMode)
);

// File: tb/palDacSequencer_tb.sv
`timescale 1ns/1ps
module palDacSequencer_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  palDacSequencer u_dut (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (wrEn),
    .rdEn  (rdEn),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata)
  );

  // Vector: {isRead, addr[1:0], wdata[7:0], expect[7:0], req[3:0]}
  function automatic logic [22:0] vw(logic [1:0] a, logic [7:0] d, logic [3:0] r);
    return {1'b0, a, d, 8'h00, r};
  endfunction
  function automatic logic [22:0] vr(logic [1:0] a, logic [7:0] e, logic [3:0] r);
    return {1'b1, a, 8'h00, e, r};
  endfunction

  localparam int NVEC = 45;
  localparam logic [22:0] VEC [NVEC] = '{
    vw(2'd1, 8'h05, 4'd2),  // R2 write index 5
    vw(2'd2, 8'h11, 4'd3),  // R3
    vw(2'd2, 8'h22, 4'd3),
    vw(2'd2, 8'h33, 4'd4),  // R4 commit entry 5
    vw(2'd2, 8'h44, 4'd3),
    vw(2'd2, 8'h55, 4'd3),
    vw(2'd2, 8'h66, 4'd4),  // R4 commit entry 6
    vr(2'd1, 8'h07, 4'd7),  // R7 write index now 7
    vr(2'd3, 8'h00, 4'd7),  // R7 state after write load
    vw(2'd0, 8'h05, 4'd1),  // R1 read index 5
    vr(2'd3, 8'h03, 4'd1),  // R1 state 3
    vr(2'd2, 8'h11, 4'd6),  // R6
    vr(2'd2, 8'h22, 4'd6),
    vr(2'd2, 8'h33, 4'd6),
    vr(2'd2, 8'h44, 4'd6),  // R6 auto-advance to entry 6
    vr(2'd2, 8'h55, 4'd6),
    vr(2'd2, 8'h66, 4'd6),
    vr(2'd0, 8'h00, 4'd7),  // R7 port 0 reads zero
    vr(2'd1, 8'h07, 4'd7),  // R7 reads do not move write index
    vw(2'd1, 8'h14, 4'd5),  // R5 partial entry 20
    vw(2'd2, 8'hAA, 4'd5),
    vw(2'd2, 8'hBB, 4'd5),
    vw(2'd0, 8'h14, 4'd5),
    vr(2'd2, 8'h00, 4'd5),  // R5 entry 20 untouched
    vr(2'd2, 8'h00, 4'd5),
    vr(2'd2, 8'h00, 4'd5),
    vw(2'd1, 8'h14, 4'd4),
    vw(2'd2, 8'h01, 4'd4),
    vw(2'd2, 8'h02, 4'd4),
    vw(2'd2, 8'h03, 4'd4),
    vr(2'd1, 8'h15, 4'd4),  // R4 write index incremented
    vw(2'd0, 8'h14, 4'd4),
    vr(2'd2, 8'h01, 4'd4),
    vr(2'd2, 8'h02, 4'd4),
    vr(2'd2, 8'h03, 4'd4),
    vw(2'd1, 8'hFF, 4'd8),  // R8 last entry
    vw(2'd2, 8'h07, 4'd8),
    vw(2'd2, 8'h08, 4'd8),
    vw(2'd2, 8'h09, 4'd8),
    vr(2'd1, 8'h00, 4'd8),  // R8 write index wrapped
    vw(2'd0, 8'hFF, 4'd8),
    vr(2'd2, 8'h07, 4'd8),
    vr(2'd2, 8'h08, 4'd8),
    vr(2'd2, 8'h09, 4'd8),
    vr(2'd2, 8'h00, 4'd8)   // R8 read index wrapped to entry 0
  };

  task automatic check(input logic [7:0] exp, input int req, input string what);
    total++;
    if (rdata !== exp) begin
      bad++;
      $display("FAIL R%0d %s actual=0x%02h expected=0x%02h", req, what, rdata, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, input logic [7:0] exp, input int req, input string what);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    check(exp, req, what);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    doReset();
    // R10 reset state
    check(8'h00, 10, "rdata after reset");
    busRead(2'd1, 8'h00, 10, "write index after reset");
    busRead(2'd3, 8'h00, 10, "state after reset");
    busRead(2'd2, 8'h00, 10, "entry 0 after reset");
    doReset();

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][22]) begin
        busRead(VEC[i][21:20], VEC[i][11:4], int'(VEC[i][3:0]), $sformatf("vector %0d", i));
      end else begin
        busWrite(VEC[i][21:20], VEC[i][19:12]);
      end
    end

    // R9 write and read strobes in the same cycle on the data port
    busWrite(2'd1, 8'h1E);
    busRead(2'd1, 8'h1E, 9, "write index before collision");
    @(negedge clk);
    wrEn = 1'b1; rdEn = 1'b1; addr = 2'd2; wdata = 8'h77;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    check(8'h1E, 9, "rdata held through collision");
    busWrite(2'd2, 8'h88);
    busWrite(2'd2, 8'h99);
    busRead(2'd1, 8'h1F, 9, "entry committed after two more writes");
    busWrite(2'd0, 8'h1E);
    busRead(2'd2, 8'h77, 9, "collided byte in slot 0");
    busRead(2'd2, 8'h88, 9, "slot 1");
    busRead(2'd2, 8'h99, 9, "slot 2");

    // R10 reset mid-run clears table and indices
    doReset();
    check(8'h00, 10, "rdata after second reset");
    busRead(2'd1, 8'h00, 10, "write index after second reset");
    busWrite(2'd0, 8'h05);
    busRead(2'd2, 8'h00, 10, "entry 5 cleared by reset");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule